// File: doc/BRIEF.md
# Stereo/Mono Channel Converter

This block sits in an audio sample stream and changes how many channels the stream carries. Each sample travels with a one-bit channel tag: 0 marks the first (left) channel and 1 marks the second (right) channel. Samples enter and leave over valid/ready handshakes. Two static mode inputs choose the conversion.

In the reducing direction, a stereo stream becomes mono. The block keeps the first channel, keeps the second channel, or outputs the floor-rounded mean of the two. In the expanding direction, a mono stream becomes stereo. The block emits each input twice, with the second copy either zeroed or duplicated. When neither direction is requested, the stream passes through unchanged.

Every path has a registered output and honours back-pressure: while the output is stalled, the block neither loses nor repeats a sample. The mode inputs are meant to change only while reset is held.

Top module: `chan_conv_top`

## Requirements
- R1: While reset is high, and in the cycle after it falls, out_valid is low and in_ready is high.
- R2: The expand code takes priority over the reduce code. An expand code of 1 (zero fill) or 2 (copy) selects expansion whatever the reduce code is. An expand code of 0 or 3 leaves the choice to the reduce code: 0 pass-through, 1 keep channel 0, 2 keep channel 1, 3 average.
- R3: In pass-through, every accepted sample appears exactly once at the output, in order, with its data and channel tag unchanged.
- R4: In keep-channel-0 and keep-channel-1 modes, each completed pair yields one output tagged 0 that carries the selected sample of the pair.
- R5: In average mode, the output is (a + b) >>> 1 on signed two's-complement samples. The sum is formed one bit wider than a sample, so the result rounds toward negative infinity.
- R6: A pair is a channel-0 sample followed by a channel-1 sample. A channel-1 sample that arrives with no channel-0 sample held produces no output. A second channel-0 sample replaces the one already held.
- R7: In expand mode, each input produces two outputs, tagged 0 and then 1. In zero-fill mode the tag-1 output carries 0.
- R8: In copy mode, both outputs of an input carry the input sample.
- R9: While out_valid is high and out_ready is low, out_data and out_chan hold steady, out_valid stays high, and in_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reduce_mode_i | input | 2 | Reduce code: 0 none, 1 keep ch0, 2 keep ch1, 3 average |
| expand_mode_i | input | 2 | Expand code: 0 none, 1 zero fill, 2 copy, 3 none |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | SAMPLE_W | Signed input sample |
| in_chan | input | 1 | Input channel tag |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | SAMPLE_W | Signed output sample |
| out_chan | output | 1 | Output channel tag |

## Verification
The bench uses a 4-bit sample width and sweeps all 256 operand pairs in average mode. That sweep catches a truncating divide or a sum that overflows instead of rounding toward negative infinity: either error yields a wrong value on negative or extreme operands. Orphan channel-1 samples and repeated channel-0 samples are injected to show that a design pairing by arrival count would emit spurious outputs. A pseudo-random output stall runs through every mode, so a design that drops or repeats a sample at a stall loses sync with the expected stream. Mode codes that request both directions, or that use the spare expand code, show whether the priority has been inverted.

// File: rtl/chconv_pkg.sv
`timescale 1ns/1ps
package chconv_pkg;

    typedef enum logic [1:0] {
        RED_NONE = 2'd0,
        RED_CH0  = 2'd1,
        RED_CH1  = 2'd2,
        RED_AVG  = 2'd3
    } reduce_e;

    typedef enum logic [1:0] {
        EXP_NONE = 2'd0,
        EXP_ZERO = 2'd1,
        EXP_COPY = 2'd2,
        EXP_SPARE = 2'd3
    } expand_e;

    typedef enum logic [1:0] {
        PATH_PASS   = 2'd0,
        PATH_REDUCE = 2'd1,
        PATH_EXPAND = 2'd2
    } path_e;

    typedef struct packed {
        path_e   path;
        reduce_e red;
        logic    zero_fill;
    } route_t;

    localparam logic CHAN_FIRST  = 1'b0;
    localparam logic CHAN_SECOND = 1'b1;

    // Expansion outranks reduction (R2)
    function automatic route_t resolve_route(input logic [1:0] red_code,
                                             input logic [1:0] exp_code);
        route_t r;
        r.red       = reduce_e'(red_code);
        r.zero_fill = (expand_e'(exp_code) == EXP_ZERO);
        if (expand_e'(exp_code) == EXP_ZERO || expand_e'(exp_code) == EXP_COPY)
            r.path = PATH_EXPAND;
        else if (reduce_e'(red_code) != RED_NONE)
            r.path = PATH_REDUCE;
        else
            r.path = PATH_PASS;
        return r;
    endfunction

endpackage

// File: rtl/chconv_pass.sv
`timescale 1ns/1ps
module chconv_pass #(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                in_chan,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_chan
);
    logic                vld_q;
    logic [SAMPLE_W-1:0] dat_q;
    logic                chn_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
        end else if (in_ready) begin
            vld_q <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
            dat_q <= in_data;
            chn_q <= in_chan;
        end
    end

    assign out_valid = vld_q;
    assign out_data  = dat_q;
    assign out_chan  = chn_q;
endmodule

// File: rtl/chconv_reduce.sv
`timescale 1ns/1ps
module chconv_reduce
    import chconv_pkg::*;
#(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  reduce_e             sel,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                in_chan,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_chan
);
    localparam int SUM_W = SAMPLE_W + 1;

    logic                held_v;
    logic [SAMPLE_W-1:0] held_d;
    logic                vld_q;
    logic [SAMPLE_W-1:0] dat_q;
    logic                accept;
    logic                pair_done;
    logic signed [SUM_W-1:0] sum;
    logic [SAMPLE_W-1:0] pick;

    assign in_ready  = !vld_q || out_ready;
    assign accept    = in_valid && in_ready;
    assign pair_done = accept && (in_chan == CHAN_SECOND) && held_v;

    // One extra bit keeps the sum exact; dropping bit 0 floors it (R5)
    assign sum = $signed({held_d[SAMPLE_W-1], held_d}) + $signed({in_data[SAMPLE_W-1], in_data});

    always_comb begin
        case (sel)
            RED_CH1: pick = in_data;
            RED_AVG: pick = sum[SUM_W-1:1];
            default: pick = held_d;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            if (vld_q && out_ready)
                vld_q <= 1'b0;
            if (pair_done)
                vld_q <= 1'b1;
            if (accept && in_chan == CHAN_FIRST)
                held_v <= 1'b1;
            else if (pair_done)
                held_v <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (accept && in_chan == CHAN_FIRST)
            held_d <= in_data;
        if (pair_done)
            dat_q <= pick;
    end

    assign out_valid = vld_q;
    assign out_data  = dat_q;
    assign out_chan  = CHAN_FIRST;
endmodule

// File: rtl/chconv_expand.sv
`timescale 1ns/1ps
module chconv_expand
    import chconv_pkg::*;
#(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                zero_fill,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_chan
);
    logic                busy;
    logic                phase;
    logic [SAMPLE_W-1:0] dat_q;
    logic                accept;

    assign in_ready = !busy || (phase && out_ready);
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            phase <= CHAN_FIRST;
        end else if (accept) begin
            busy  <= 1'b1;
            phase <= CHAN_FIRST;
        end else if (busy && out_ready) begin
            if (phase == CHAN_FIRST)
                phase <= CHAN_SECOND;
            else
                busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (accept)
            dat_q <= in_data;
    end

    assign out_valid = busy;
    assign out_chan  = phase;
    assign out_data  = (phase == CHAN_SECOND && zero_fill) ? '0 : dat_q;
endmodule

// File: rtl/chan_conv_top.sv
`timescale 1ns/1ps
module chan_conv_top
    import chconv_pkg::*;
#(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          reduce_mode_i,
    input  logic [1:0]          expand_mode_i,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                in_chan,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_chan
);
    route_t route;
    assign route = resolve_route(reduce_mode_i, expand_mode_i);

    logic sel_pass, sel_red, sel_exp;
    assign sel_pass = (route.path == PATH_PASS);
    assign sel_red  = (route.path == PATH_REDUCE);
    assign sel_exp  = (route.path == PATH_EXPAND);

    logic                p_rdy, p_vld, p_chn;
    logic [SAMPLE_W-1:0] p_dat;
    logic                r_rdy, r_vld, r_chn;
    logic [SAMPLE_W-1:0] r_dat;
    logic                e_rdy, e_vld, e_chn;
    logic [SAMPLE_W-1:0] e_dat;

    chconv_pass #(.SAMPLE_W(SAMPLE_W)) u_pass (
        .clk(clk), .rst(rst),
        .in_valid(in_valid && sel_pass), .in_ready(p_rdy),
        .in_data(in_data), .in_chan(in_chan),
        .out_valid(p_vld), .out_ready(out_ready && sel_pass),
        .out_data(p_dat), .out_chan(p_chn)
    );

    chconv_reduce #(.SAMPLE_W(SAMPLE_W)) u_reduce (
        .clk(clk), .rst(rst), .sel(route.red),
        .in_valid(in_valid && sel_red), .in_ready(r_rdy),
        .in_data(in_data), .in_chan(in_chan),
        .out_valid(r_vld), .out_ready(out_ready && sel_red),
        .out_data(r_dat), .out_chan(r_chn)
    );

    chconv_expand #(.SAMPLE_W(SAMPLE_W)) u_expand (
        .clk(clk), .rst(rst), .zero_fill(route.zero_fill),
        .in_valid(in_valid && sel_exp), .in_ready(e_rdy),
        .in_data(in_data),
        .out_valid(e_vld), .out_ready(out_ready && sel_exp),
        .out_data(e_dat), .out_chan(e_chn)
    );

    always_comb begin
        case (route.path)
            PATH_REDUCE: begin
                in_ready = r_rdy; out_valid = r_vld; out_data = r_dat; out_chan = r_chn;
            end
            PATH_EXPAND: begin
                in_ready = e_rdy; out_valid = e_vld; out_data = e_dat; out_chan = e_chn;
            end
            default: begin
                in_ready = p_rdy; out_valid = p_vld; out_data = p_dat; out_chan = p_chn;
            end
        endcase
    end
endmodule

// File: rtl/chconv_checker.sv
`timescale 1ns/1ps
module chconv_checker #(
    parameter int SAMPLE_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          reduce_mode_i,
    input logic [1:0]          expand_mode_i,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [SAMPLE_W-1:0] out_data,
    input logic                out_chan
);
    logic exp_on, zero_on, copy_on, red_on;
    assign zero_on = (expand_mode_i == 2'd1);
    assign copy_on = (expand_mode_i == 2'd2);
    assign exp_on  = zero_on || copy_on;
    assign red_on  = !exp_on && (reduce_mode_i != 2'd0);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan));

    p_backpressure_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    p_reduce_tag_r4: assert property (@(posedge clk) disable iff (rst)
        red_on && out_valid |-> out_chan == 1'b0);

    p_expand_order_r7: assert property (@(posedge clk) disable iff (rst)
        exp_on && out_valid && out_ready && !out_chan |=> out_valid && out_chan);

    p_zero_fill_r7: assert property (@(posedge clk) disable iff (rst)
        zero_on && out_valid && out_chan |-> out_data == '0);

    p_copy_dup_r8: assert property (@(posedge clk) disable iff (rst)
        copy_on && out_valid && out_ready && !out_chan |=> out_data == $past(out_data));
endmodule

bind chan_conv_top chconv_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk(clk), .rst(rst),
    .reduce_mode_i(reduce_mode_i), .expand_mode_i(expand_mode_i),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_chan(out_chan)
);

// File: tb/chan_conv_top_tb_top.sv
`timescale 1ns/1ps
module chan_conv_top_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   reduce_mode_i = 2'd0;
    logic [1:0]   expand_mode_i = 2'd0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic         in_chan = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [W-1:0] out_data;
    logic         out_chan;

    always #4 clk = ~clk;

    chan_conv_top #(.SAMPLE_W(W)) dut_i (
        .clk(clk), .rst(rst),
        .reduce_mode_i(reduce_mode_i), .expand_mode_i(expand_mode_i),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_chan(in_chan),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_chan(out_chan)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R3";

    logic [W-1:0] exp_d [0:2047];
    logic         exp_c [0:2047];
    int wr_idx = 0;
    int rd_idx = 0;

    logic         m_held = 1'b0;
    logic [W-1:0] m_hd = '0;
    logic         stall_en = 1'b0;
    logic [7:0]   lfsr = 8'hA5;

    task automatic check(input bit ok, input string req, input int act, input int expv, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic add_exp(input logic [W-1:0] d, input logic c);
        exp_d[wr_idx] = d;
        exp_c[wr_idx] = c;
        wr_idx++;
    endtask

    // Bench-side model of the expected output stream
    task automatic model(input logic [W-1:0] d, input logic c);
        integer s;
        if (expand_mode_i == 2'd1 || expand_mode_i == 2'd2) begin
            add_exp(d, 1'b0);
            add_exp((expand_mode_i == 2'd1) ? '0 : d, 1'b1);
        end else if (reduce_mode_i == 2'd0) begin
            add_exp(d, c);
        end else if (c == 1'b0) begin
            m_held = 1'b1;
            m_hd = d;
        end else if (m_held) begin
            m_held = 1'b0;
            if (reduce_mode_i == 2'd1) add_exp(m_hd, 1'b0);
            else if (reduce_mode_i == 2'd2) add_exp(d, 1'b0);
            else begin
                s = $signed(m_hd) + $signed(d);
                s = s >>> 1;
                add_exp(s[W-1:0], 1'b0);
            end
        end
    endtask

    task automatic send(input logic [W-1:0] d, input logic c);
        @(negedge clk);
        in_valid = 1'b1;
        in_data = d;
        in_chan = c;
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        model(d, c);
    endtask

    task automatic apply_mode(input logic [1:0] r, input logic [1:0] e);
        @(negedge clk);
        rst = 1'b1;
        reduce_mode_i = r;
        expand_mode_i = e;
        m_held = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        check(out_valid == 1'b0, "R1", out_valid, 0, "out_valid in reset");
        check(in_ready == 1'b1, "R1", in_ready, 1, "in_ready in reset");
        rst = 1'b0;
        @(negedge clk);
        #2;
        check(out_valid == 1'b0, "R1", out_valid, 0, "out_valid after reset");
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (rd_idx != wr_idx && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (10) @(negedge clk);
        check(rd_idx == wr_idx, req, rd_idx, wr_idx, "output count");
    endtask

    // Output ready pattern
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = stall_en ? lfsr[0] : 1'b1;
        end
    end

    // Output monitor
    initial begin
        bit           pstall = 0;
        logic [W-1:0] pd = '0;
        logic         pc = 1'b0;
        forever begin
            @(negedge clk);
            #2;
            if (rst) begin
                pstall = 0;
            end else begin
                if (pstall) begin
                    check(out_valid && out_data == pd && out_chan == pc, "R9",
                          {out_valid, out_chan, out_data}, {1'b1, pc, pd}, "held under stall");
                end
                if (out_valid && !out_ready)
                    check(!in_ready, "R9", in_ready, 0, "in_ready under stall");
                if (out_valid && out_ready) begin
                    if (rd_idx >= wr_idx) begin
                        check(1'b0, cur_req, {out_chan, out_data}, -1, "unexpected output");
                    end else begin
                        check(out_data == exp_d[rd_idx] && out_chan == exp_c[rd_idx], cur_req,
                              {out_chan, out_data}, {exp_c[rd_idx], exp_d[rd_idx]}, "output sample");
                        rd_idx++;
                    end
                end
                pstall = out_valid && !out_ready;
                pd = out_data;
                pc = out_chan;
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", rd_idx, wr_idx);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R3 pass-through
        cur_req = "R3";
        apply_mode(2'd0, 2'd0);
        for (int i = 0; i < 16; i++) send(i[W-1:0], i[0]);
        drain("R3");
        stall_en = 1'b1;
        for (int i = 0; i < 32; i++) send(W'(i * 7), i[1]);
        drain("R9");

        // R4 keep channel 0, then R6 pairing corners
        stall_en = 1'b0;
        cur_req = "R4";
        apply_mode(2'd1, 2'd0);
        for (int i = 0; i < 16; i++) begin
            send(i[W-1:0], 1'b0);
            send(W'(15 - i), 1'b1);
        end
        drain("R4");
        cur_req = "R6";
        send(4'd5, 1'b1);
        send(4'd3, 1'b0);
        send(4'd7, 1'b0);
        send(4'd9, 1'b1);
        send(4'd2, 1'b1);
        drain("R6");
        check(wr_idx > 0 && exp_d[wr_idx-1] == 4'd7, "R6", exp_d[wr_idx-1], 7, "replaced held sample");

        // R4 keep channel 1
        cur_req = "R4";
        stall_en = 1'b1;
        apply_mode(2'd2, 2'd0);
        for (int i = 0; i < 16; i++) begin
            send(i[W-1:0], 1'b0);
            send(W'(i + 5), 1'b1);
        end
        send(4'd11, 1'b1);
        drain("R4");

        // R5 exhaustive average sweep
        cur_req = "R5";
        apply_mode(2'd3, 2'd0);
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                send(a[W-1:0], 1'b0);
                send(b[W-1:0], 1'b1);
            end
        drain("R5");

        // R7 zero fill, R8 copy
        cur_req = "R7";
        apply_mode(2'd0, 2'd1);
        for (int i = 0; i < 16; i++) send(i[W-1:0], 1'b0);
        drain("R7");
        cur_req = "R8";
        apply_mode(2'd0, 2'd2);
        for (int i = 0; i < 16; i++) send(W'(15 - i), 1'b0);
        drain("R8");

        // R2 priority: copy wins over average; spare expand code defers to keep ch0
        cur_req = "R2";
        apply_mode(2'd3, 2'd2);
        for (int i = 0; i < 8; i++) send(W'(i + 3), i[0]);
        drain("R2");
        apply_mode(2'd1, 2'd3);
        for (int i = 0; i < 8; i++) begin
            send(W'(i + 8), 1'b0);
            send(i[W-1:0], 1'b1);
        end
        drain("R2");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule